// File: doc/BRIEF.md
# Charge-Switch Duty-Factor Gate

This block decides, clock by clock, whether the current-regulation comparator may turn on the external pass switch of a single-cell charger. It divides each charge period into 64 equal slots, advances one slot per base-tick pulse, and lets the comparator through only during the first few slots of the period. The active charge mode sets how many: nearly all for fast charge, a quarter for precharge or top-off, and a single slot for maintenance. The switch drive is active low. A high level holds the switch open.

The first disabled slot of each period is marked by a measure-window strobe, so that an unloaded cell voltage can be sampled there. A cell-test request holds the switch open for as long as it is asserted and keeps the strobe high throughout. The mode select, tick and test request are registered and take effect on the next clock edge. The comparator input reaches the switch drive through logic only, so it is not delayed by a clock.

Top module: `dfg_gate`

## Requirements
- R1: While reset is asserted and immediately after it is released, the block is in the off mode at slot 0. In this state gate_en is 0, sw_n is 1 and meas_win is 0.
- R2: The slot counter counts 64 slots (0 to 63). It advances by one on each clock edge where tick is 1 and the mode did not change, and wraps from 63 to 0. Without a tick it holds its value.
- R3: In fast mode (mode_sel = 2'b01), gate_en is 1 in slots 0 to 61 and 0 in slots 62 and 63. This is 62 of 64 slots.
- R4: In precharge/top-off mode (mode_sel = 2'b10), gate_en is 1 in slots 0 to 15 only. This is 16 of 64 slots.
- R5: In maintenance mode (mode_sel = 2'b11), gate_en is 1 in slot 0 only. This is 1 of 64 slots.
- R6: In off mode (mode_sel = 2'b00), gate_en and meas_win are 0 and sw_n is 1, whatever tick and cmp_on do.
- R7: At the clock edge after mode_sel differs from the registered mode, the new mode takes effect and the counter restarts at slot 0. A tick in that same cycle is ignored.
- R8: In each charging mode, meas_win is 1 exactly in the slot whose number equals that mode's enabled-slot count (62, 16 or 1). It is 0 in every other slot, and it is never 1 at the same time as gate_en.
- R9: At the clock edge after test_req is 1, gate_en goes to 0 and meas_win goes to 1, and both stay that way until the edge after test_req returns to 0. The slot counter keeps running during the request.
- R10: sw_n equals NOT(gate_en AND cmp_on) with no clock delay. Charging current flows only when sw_n is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Charge mode: 00 off, 01 fast, 10 precharge/top-off, 11 maintenance |
| tick | input | 1 | Base time-slot advance pulse |
| test_req | input | 1 | Cell-test request; holds the switch open |
| cmp_on | input | 1 | Output of the hysteretic current comparator (1 = wants current) |
| gate_en | output | 1 | Duty-factor enable for the comparator |
| sw_n | output | 1 | Active-low pass-switch drive |
| meas_win | output | 1 | Unloaded-measurement window strobe |

## Verification
The mode select, tick and test request are sampled on a rising edge. Their effect on gate_en and meas_win appears after that one edge, so the bench drives these inputs on a falling edge and compares the outputs on the next falling edge against the slot and mode it tracks itself. cmp_on is the one input with zero latency: the bench changes it between edges and reads sw_n a nanosecond later, with no clock edge in between. Duty fractions are checked by counting enabled samples over one whole 64-slot period that starts from the restart slot.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
  typedef enum logic [1:0] {
    DF_OFF     = 2'd0,
    DF_FAST    = 2'd1,
    DF_TRICKLE = 2'd2,
    DF_MAINT   = 2'd3
  } df_mode_e;

  localparam int DF_NUM_MODES = 4;
endpackage

// File: rtl/dfg_slot_ctr.sv
module dfg_slot_ctr #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot
);
  logic [SLOT_W-1:0] slot_q, slot_d;

  // A restart has priority over an advance in the same cycle.
  always_comb begin
    slot_d = slot_q;
    if (restart)  slot_d = '0;
    else if (adv) slot_d = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;
endmodule

// File: rtl/dfg_slice_dec.sv
module dfg_slice_dec
  import dfg_pkg::*;
#(
  parameter int SLOT_W     = 6,
  parameter int FAST_ON    = 62,
  parameter int TRICKLE_ON = 16,
  parameter int MAINT_ON   = 1
) (
  input  df_mode_e          mode,
  input  logic [SLOT_W-1:0] slot,
  input  logic              block,
  output logic              gate,
  output logic              meas
);
  localparam int LIM_W = SLOT_W + 1;

  logic [DF_NUM_MODES-1:0] on_v;
  logic [DF_NUM_MODES-1:0] edge_v;
  logic [LIM_W-1:0]        slot_x;

  assign slot_x = {1'b0, slot};

  for (genvar m = 0; m < DF_NUM_MODES; m++) begin : g_mode
    if (m == 0) begin : g_off
      assign on_v[m]   = 1'b0;
      assign edge_v[m] = 1'b0;
    end else begin : g_chg
      localparam int LIM = (m == 1) ? FAST_ON : (m == 2) ? TRICKLE_ON : MAINT_ON;
      assign on_v[m]   = slot_x <  LIM_W'(LIM);
      assign edge_v[m] = slot_x == LIM_W'(LIM);
    end
  end

  always_comb begin
    gate = on_v[mode] & ~block;
    meas = edge_v[mode] | block;
  end
endmodule

// File: rtl/dfg_gate.sv
module dfg_gate
  import dfg_pkg::*;
#(
  parameter int SLOT_W     = 6,
  parameter int FAST_ON    = 62,
  parameter int TRICKLE_ON = 16,
  parameter int MAINT_ON   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       tick,
  input  logic       test_req,
  input  logic       cmp_on,
  output logic       gate_en,
  output logic       sw_n,
  output logic       meas_win
);
  df_mode_e          mode_q, mode_d;
  logic              test_q, test_d;
  logic              restart;
  logic [SLOT_W-1:0] slot_q;
  logic              gate_w, meas_w;

  always_comb begin
    mode_d  = df_mode_e'(mode_sel);
    test_d  = test_req;
    restart = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DF_OFF;
      test_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      test_q <= test_d;
    end
  end

  dfg_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (tick),
    .slot    (slot_q)
  );

  dfg_slice_dec #(
    .SLOT_W     (SLOT_W),
    .FAST_ON    (FAST_ON),
    .TRICKLE_ON (TRICKLE_ON),
    .MAINT_ON   (MAINT_ON)
  ) u_dec (
    .mode  (mode_q),
    .slot  (slot_q),
    .block (test_q),
    .gate  (gate_w),
    .meas  (meas_w)
  );

  assign gate_en  = gate_w;
  assign meas_win = meas_w;
  assign sw_n     = ~(gate_w & cmp_on);
endmodule

// File: rtl/dfg_gate_chk.sv
module dfg_gate_chk #(
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              tick,
  input logic              test_req,
  input logic              cmp_on,
  input logic              gate_en,
  input logic              sw_n,
  input logic              meas_win,
  input logic [1:0]        mode_q,
  input logic [SLOT_W-1:0] slot_q
);
  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !test_req) |=> (!gate_en && !meas_win && sw_n));

  // R9
  test_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |=> (!gate_en && meas_win));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != mode_q) |=> (slot_q == '0));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_sel == mode_q) |=> (slot_q == $past(slot_q) + SLOT_W'(1)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && mode_sel == mode_q) |=> $stable(slot_q));

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_en, meas_win}));

  // R10
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en || !cmp_on) |-> sw_n);
endmodule

bind dfg_gate dfg_gate_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .tick     (tick),
  .test_req (test_req),
  .cmp_on   (cmp_on),
  .gate_en  (gate_en),
  .sw_n     (sw_n),
  .meas_win (meas_win),
  .mode_q   (mode_q),
  .slot_q   (slot_q)
);

// File: tb/tb_dfg_gate.sv
module tb_dfg_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       tick, test_req, cmp_on;
  logic       gate_en, sw_n, meas_win;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_mode = 0;
  int m_slot = 0;
  bit m_test = 0;

  always #5 clk = ~clk;

  dfg_gate dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tick(tick),
    .test_req(test_req), .cmp_on(cmp_on), .gate_en(gate_en),
    .sw_n(sw_n), .meas_win(meas_win)
  );

  function automatic int on_cnt(input int md);
    case (md)
      1: return 62;
      2: return 16;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {gate,sw_n,meas} actual=%b expected=%b (mode %0d slot %0d)",
               tag, act, exp, m_mode, m_slot);
    end
  endtask

  task automatic check_model(input string tag);
    bit g, m;
    g = (m_mode != 0) && (m_slot < on_cnt(m_mode)) && !m_test;
    m = m_test || ((m_mode != 0) && (m_slot == on_cnt(m_mode)));
    check(tag, {gate_en, sw_n, meas_win}, {g, ~(g & cmp_on), m});
  endtask

  // Called at a falling edge; checks at the next falling edge.
  task automatic step(input logic [1:0] md, input logic tk, input logic tr,
                      input logic cp, input string tag);
    mode_sel = md; tick = tk; test_req = tr; cmp_on = cp;
    @(posedge clk);
    if (int'(md) != m_mode) begin
      m_mode = int'(md);
      m_slot = 0;
    end else if (tk) begin
      m_slot = (m_slot + 1) % 64;
    end
    m_test = tr;
    @(negedge clk);
    check_model(tag);
  endtask

  function automatic string mode_tag(input int md);
    case (md)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    int cnt;
    rst_n = 1'b0; mode_sel = 2'b00; tick = 1'b0; test_req = 1'b0; cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1", {gate_en, sw_n, meas_win}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: after release
    check("R1", {gate_en, sw_n, meas_win}, 3'b010);

    // R6: off mode with ticks and comparator active
    for (int i = 0; i < 20; i++) step(2'b00, 1'b1, 1'b0, i[0], "R6");

    // R3/R4/R5 with R8: each mode, ticks every cycle, duty over one period
    for (int md = 1; md < 4; md++) begin
      cnt = 0;
      for (int i = 0; i < 64; i++) begin
        step(2'(md), 1'b1, 1'b0, 1'b1, mode_tag(md));
        if (gate_en) cnt++;
      end
      n_chk++;
      if (cnt != on_cnt(md)) begin
        n_bad++;
        $display("FAIL %s: duty count actual=%0d expected=%0d", mode_tag(md), cnt, on_cnt(md));
      end
      // second period, ticks spaced 3 cycles, covers wrap and hold (R2, R8)
      for (int i = 0; i < 200; i++)
        step(2'(md), (i % 3) == 0, 1'b0, i[1], (i % 3) != 0 ? "R2" : "R8");
    end

    // R7: mode change with a simultaneous tick restarts at slot 0
    for (int i = 0; i < 20; i++) step(2'b01, 1'b1, 1'b0, 1'b1, "R2");
    step(2'b10, 1'b1, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 20; i++) step(2'b10, 1'b1, 1'b0, 1'b1, "R7");
    step(2'b11, 1'b1, 1'b0, 1'b1, "R7");
    step(2'b01, 1'b0, 1'b0, 1'b1, "R7");

    // R9: test request pulses in fast mode, counter keeps running
    for (int i = 0; i < 40; i++)
      step(2'b01, 1'b1, (i >= 5 && i < 9) || i == 20, 1'b1, "R9");
    // R9: test request in maintenance mode
    for (int i = 0; i < 10; i++) step(2'b11, 1'b1, i == 3, 1'b1, "R9");

    // R10: comparator passes through without a clock edge
    step(2'b01, 1'b0, 1'b0, 1'b1, "R10");
    for (int i = 0; i < 4; i++) begin
      cmp_on = i[0];
      #1;
      check_model("R10");
    end
    step(2'b11, 1'b1, 1'b0, 1'b1, "R10");
    step(2'b11, 1'b1, 1'b0, 1'b1, "R10");
    cmp_on = 1'b0; #1; check_model("R10");
    cmp_on = 1'b1; #1; check_model("R10");

    // R6: back to off
    for (int i = 0; i < 5; i++) step(2'b00, 1'b1, 1'b0, 1'b1, "R6");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule